// File: doc/BRIEF.md
# Receive Byte-Ready Qualifier and Framer

This block is the parallel output stage of an 8b/10b serial receiver. Characters arrive one per byte period, already deserialized and decoded, on a fast clock with `TICKS_PER_CHAR` cycles per byte. A one-cycle `in_valid` marks each arrival, and a flag marks the comma character K28.5. The block drives a 10-bit data bus and two status bits. It also drives `rdy_n`, an active-low byte-ready strobe that a FIFO can use directly as its write pulse.

Each character is held for one byte period, so the block can see the character that follows it before deciding on its strobe. A comma followed by another comma is a fill character and produces no strobe. The last comma of a run is followed by something else, so it is delivered with a normal strobe. After reset, and whenever `frame_req` rises, the block hunts for a comma and keeps the strobe off until one arrives. A strobe therefore also tells the receiving logic that framing is correct.

In bypass mode the raw 10-bit code goes to the outputs without decoding. If `frame_req` is also high, the strobe marks every comma received and nothing else.

Top module: `rx_byte_qualifier`

## Requirements
- R1: During and after synchronous reset, `rdy_n` is 1 and `q_data`, `q_special` and `q_viol` are 0 until the first character is released.
- R2: On the clock edge where a new character is captured, the character captured before it appears on `q_data`, `q_special` and `q_viol`, all updated together. Between releases the outputs hold their value.
- R3: A character captured with `bypass`=0 is output as `q_data = {2'b00, in_code[7:0]}` with `q_special = in_special`. A character captured with `bypass`=1 is output as `q_data = in_code[9:0]` with `q_special = 0`. `q_viol` always equals the captured `in_viol`.
- R4: A comma (`in_comma`=1) that is directly followed by another comma is a fill character. When it is released, `rdy_n` stays high.
- R5: A comma followed by any non-comma character, including one with `in_viol`=1, is released with a normal strobe.
- R6: A strobe drives `rdy_n` low for exactly `LOW_TICKS = TICKS_PER_CHAR*LOW_PCT/100` cycles (at least 1). It starts in the cycle after the release edge.
- R7: After reset the block hunts. Characters captured while hunting are released without a strobe. A comma ends the hunt, and that comma and every character after it qualify.
- R8: A rising edge of `frame_req` restarts the hunt, with the same strobe inhibition as R7, until the next comma.
- R9: A character captured with `bypass`=1 and `frame_req`=1 gets a strobe only if it is a comma, including each comma of a fill run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, `TICKS_PER_CHAR` cycles per byte period |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One-cycle marker of a new character |
| in_code | input | 10 | Decoded byte in bits 7:0, or the raw 10-bit code in bypass |
| in_special | input | 1 | Decoded special-character flag |
| in_viol | input | 1 | Code-rule violation flag |
| in_comma | input | 1 | Character is K28.5 |
| frame_req | input | 1 | Framing request; a rising edge starts a hunt |
| bypass | input | 1 | Raw 10-bit pass-through mode |
| q_data | output | 10 | Released character |
| q_special | output | 1 | Released special flag |
| q_viol | output | 1 | Released violation flag |
| rdy_n | output | 1 | Active-low byte-ready strobe |

## Verification
The bench builds the block with `TICKS_PER_CHAR`=5 and `LOW_PCT`=60, which gives a three-cycle strobe in a five-cycle byte period. With this small timing, every byte period can be sampled cycle by cycle and the strobe width counted exactly. The configuration also makes it cheap to sweep every three-character sequence of comma, plain data and violation data under all four combinations of `bypass` and `frame_req`. That sweep reaches every pairing the lookahead decision depends on. Directed runs add a long fill string, the hunt after reset, and a hunt restarted by a rising `frame_req`.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // One held character with the tags fixed at capture time
    typedef struct packed {
        logic [9:0] code;
        logic       special;
        logic       viol;
        logic       comma;
        logic       framed;   // captured after the hunt ended (or is the ending comma)
        logic       byp;      // captured in bypass mode
        logic       byp_rf;   // captured in bypass mode with frame_req high
    } rxq_char_t;

    function automatic logic [9:0] rxq_out_code(rxq_char_t c);
        return c.byp ? c.code : {2'b00, c.code[7:0]};
    endfunction

    function automatic logic rxq_out_special(rxq_char_t c);
        return c.byp ? 1'b0 : c.special;
    endfunction

    // Strobe decision for a held character once its successor is known
    function automatic logic rxq_pulse(rxq_char_t c, logic next_is_comma);
        if (c.byp_rf)
            return c.comma;
        return c.framed && !(c.comma && next_is_comma);
    endfunction

    function automatic int rxq_low_ticks(int ticks, int pct);
        int t;
        t = (ticks * pct) / 100;
        if (t < 1) t = 1;
        if (t >= ticks) t = ticks - 1;
        if (t < 1) t = 1;
        return t;
    endfunction

endpackage

// File: rtl/rxq_capture.sv
module rxq_capture
    import rxq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [9:0]      in_code,
    input  logic            in_special,
    input  logic            in_viol,
    input  logic            in_comma,
    input  logic            frame_req,
    input  logic            bypass,
    output rxq_char_t       held,
    output logic            held_valid,
    output logic            hunting
);

    logic      rf_q;
    logic      rf_rise;
    rxq_char_t cur;

    assign rf_rise = frame_req && !rf_q;

    always_comb begin
        cur.code    = in_code;
        cur.special = in_special;
        cur.viol    = in_viol;
        cur.comma   = in_comma;
        cur.framed  = in_comma || !(hunting || rf_rise);
        cur.byp     = bypass;
        cur.byp_rf  = bypass && frame_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rf_q       <= 1'b0;
            hunting    <= 1'b1;
            held_valid <= 1'b0;
            held       <= '0;
        end else begin
            rf_q <= frame_req;
            if (in_valid && in_comma)
                hunting <= 1'b0;
            else if (rf_rise)
                hunting <= 1'b1;
            if (in_valid) begin
                held       <= cur;
                held_valid <= 1'b1;
            end
        end
    end

    // R7: a comma always ends the hunt
    assert_comma_ends_hunt_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_comma) |=> !hunting);

    // R8: a rising framing request without a comma starts a hunt
    assert_rise_starts_hunt_R8: assert property (@(posedge clk) disable iff (rst)
        (rf_rise && !(in_valid && in_comma)) |=> hunting);

endmodule

// File: rtl/rxq_release.sv
module rxq_release
    import rxq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  rxq_char_t       held,
    input  logic            held_valid,
    input  logic            in_valid,
    input  logic            in_comma,
    output logic [9:0]      q_data,
    output logic            q_special,
    output logic            q_viol,
    output logic            fire
);

    logic rel;

    assign rel  = in_valid && held_valid;
    assign fire = rel && rxq_pulse(held, in_comma);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_data    <= '0;
            q_special <= 1'b0;
            q_viol    <= 1'b0;
        end else if (rel) begin
            q_data    <= rxq_out_code(held);
            q_special <= rxq_out_special(held);
            q_viol    <= held.viol;
        end
    end

    // R2: outputs hold when nothing is released
    assert_hold_outputs_R2: assert property (@(posedge clk) disable iff (rst)
        !rel |=> ($stable(q_data) && $stable(q_viol) && $stable(q_special)));

    // R4: comma followed by comma outside bypass-framing gives no strobe
    assert_fill_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (rel && held.comma && in_comma && !held.byp_rf) |-> !fire);

    // R9: in bypass with framing request only commas fire
    assert_bypass_comma_R9: assert property (@(posedge clk) disable iff (rst)
        (rel && held.byp_rf) |-> (fire == held.comma));

endmodule

// File: rtl/rxq_strobe.sv
module rxq_strobe #(
    parameter int LOW_TICKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic rdy_n
);

    localparam int CW = $clog2(LOW_TICKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(LOW_TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_n <= 1'b1;
            cnt   <= '0;
        end else if (fire) begin
            rdy_n <= 1'b0;
            cnt   <= LOAD;
        end else if (cnt != '0) begin
            cnt   <= cnt - 1'b1;
        end else begin
            rdy_n <= 1'b1;
        end
    end

    // R6: a fire request lowers the strobe on the next cycle
    assert_fire_lowers_R6: assert property (@(posedge clk) disable iff (rst)
        fire |=> !rdy_n);

    // R6: an exhausted low phase ends on the next cycle
    assert_low_ends_R6: assert property (@(posedge clk) disable iff (rst)
        (!rdy_n && cnt == '0 && !fire) |=> rdy_n);

endmodule

// File: rtl/rx_byte_qualifier.sv
module rx_byte_qualifier
    import rxq_pkg::*;
#(
    parameter int TICKS_PER_CHAR = 5,
    parameter int LOW_PCT        = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [9:0] in_code,
    input  logic       in_special,
    input  logic       in_viol,
    input  logic       in_comma,
    input  logic       frame_req,
    input  logic       bypass,
    output logic [9:0] q_data,
    output logic       q_special,
    output logic       q_viol,
    output logic       rdy_n
);

    localparam int LOW_TICKS = rxq_low_ticks(TICKS_PER_CHAR, LOW_PCT);

    rxq_char_t held;
    logic      held_valid;
    logic      hunting;
    logic      fire;

    rxq_capture u_capture (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_code    (in_code),
        .in_special (in_special),
        .in_viol    (in_viol),
        .in_comma   (in_comma),
        .frame_req  (frame_req),
        .bypass     (bypass),
        .held       (held),
        .held_valid (held_valid),
        .hunting    (hunting)
    );

    rxq_release u_release (
        .clk        (clk),
        .rst        (rst),
        .held       (held),
        .held_valid (held_valid),
        .in_valid   (in_valid),
        .in_comma   (in_comma),
        .q_data     (q_data),
        .q_special  (q_special),
        .q_viol     (q_viol),
        .fire       (fire)
    );

    rxq_strobe #(.LOW_TICKS(LOW_TICKS)) u_strobe (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .rdy_n (rdy_n)
    );

    // R7: a strobe never starts for a character captured during a hunt
    assert_no_strobe_hunting_R7: assert property (@(posedge clk) disable iff (rst)
        (fire && !held.byp_rf) |-> held.framed);

    // R1: idle after reset until something is released
    assert_idle_before_first_R1: assert property (@(posedge clk) disable iff (rst)
        !held_valid |-> (rdy_n && q_data == '0));

endmodule

// File: tb/test_rx_byte_qualifier.sv
`timescale 1ns/1ps
module test_rx_byte_qualifier;

    localparam int TICKS = 5;
    localparam int PCT   = 60;
    localparam int LOWT  = 3;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid, in_special, in_viol, in_comma, frame_req, bypass;
    logic [9:0] in_code;
    logic [9:0] q_data;
    logic       q_special, q_viol, rdy_n;

    always #2.5 clk = ~clk;

    rx_byte_qualifier #(.TICKS_PER_CHAR(TICKS), .LOW_PCT(PCT)) i_rx_byte_qualifier (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
        .in_special(in_special), .in_viol(in_viol), .in_comma(in_comma),
        .frame_req(frame_req), .bypass(bypass), .q_data(q_data),
        .q_special(q_special), .q_viol(q_viol), .rdy_n(rdy_n)
    );

    int checks = 0;
    int fails  = 0;

    // bench model of the held character
    bit       have_prev;
    bit [9:0] p_code;
    bit       p_sp, p_vi, p_co, p_fr, p_byp, p_brf;
    bit       m_hunt;
    bit [9:0] e_data;
    bit       e_sp, e_vi;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_rf(input bit v);
        if (v && !frame_req) m_hunt = 1'b1;   // R8
        frame_req = v;
    endtask

    task automatic send(input bit [9:0] code, input bit sp, input bit vi, input bit co, input string ctx);
        bit    n_fr, n_brf, exp_pulse;
        int    lows;
        string rtag;
        n_fr  = co || !m_hunt;
        if (co) m_hunt = 1'b0;
        n_brf = bypass && frame_req;
        exp_pulse = 1'b0;
        rtag = "R7";
        if (have_prev) begin
            e_data = p_byp ? p_code : {2'b00, p_code[7:0]};
            e_sp   = p_byp ? 1'b0 : p_sp;
            e_vi   = p_vi;
            if (p_brf) begin
                exp_pulse = p_co; rtag = "R9";
            end else if (!p_fr) begin
                exp_pulse = 1'b0; rtag = "R7";
            end else if (p_co && co) begin
                exp_pulse = 1'b0; rtag = "R4";
            end else if (p_co) begin
                exp_pulse = 1'b1; rtag = "R5";
            end else begin
                exp_pulse = 1'b1; rtag = "R6";
            end
        end
        in_valid = 1'b1; in_code = code; in_special = sp; in_viol = vi; in_comma = co;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(q_data == e_data, {ctx, (have_prev && p_byp) ? " R3 data" : " R2 data"}, q_data, e_data);
        chk(q_special == e_sp && q_viol == e_vi, {ctx, " R3 flags"},
            {q_special, q_viol}, {e_sp, e_vi});
        lows = rdy_n ? 0 : 1;
        for (int k = 1; k < TICKS; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (!rdy_n) lows++;
        end
        chk(lows == (exp_pulse ? LOWT : 0), {ctx, " ", rtag, " strobe"}, lows, exp_pulse ? LOWT : 0);
        have_prev = 1'b1;
        p_code = code; p_sp = sp; p_vi = vi; p_co = co; p_fr = n_fr; p_byp = bypass; p_brf = n_brf;
    endtask

    task automatic send_type(input int t, input int idx, input string ctx);
        bit [9:0] c;
        if (t == 0) begin
            c = bypass ? 10'h0FA : 10'h005;
            send(c, 1'b1, 1'b0, 1'b1, ctx);
        end else begin
            c = 10'h2A0 + 10'(idx);
            send(c, 1'b0, t == 2, 1'b0, ctx);
        end
    endtask

    bit done = 1'b0;

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 0; in_code = '0; in_special = 0; in_viol = 0;
        in_comma = 0; frame_req = 0; bypass = 0;
        have_prev = 0; m_hunt = 1; e_data = '0; e_sp = 0; e_vi = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(rdy_n == 1'b1 && q_data == 10'd0, "R1 during reset", {rdy_n, q_data}, 11'h400);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(rdy_n == 1'b1 && q_data == 10'd0 && !q_special && !q_viol, "R1 after reset",
            {rdy_n, q_data}, 11'h400);

        // R7: hunt after reset, then a fill run of commas (R4) ending in data (R5)
        send_type(1, 1, "hunt");
        send_type(2, 2, "hunt");
        send_type(0, 0, "hunt");
        for (int i = 0; i < 5; i++) send_type(0, 0, "fill");
        send_type(1, 3, "fill");
        send_type(1, 4, "data");

        // R8: rising framing request restarts the hunt
        set_rf(1'b1);
        send_type(1, 5, "R8");
        send_type(1, 6, "R8");
        send_type(0, 0, "R8");
        send_type(2, 7, "R8");
        set_rf(1'b0);
        send_type(1, 8, "R8");

        // near-exhaustive sweep: every 3-character sequence under every mode
        for (int m = 0; m < 4; m++) begin
            bypass = m[0];
            set_rf(m[1]);
            send_type(0, 0, "sweep");
            for (int s = 0; s < 27; s++) begin
                send_type(s % 3, s, "sweep");
                send_type((s / 3) % 3, s + 32, "sweep");
                send_type(s / 9, s + 64, "sweep");
            end
            set_rf(1'b0);
        end

        // R9: bypass fill run with framing request strobes every comma
        bypass = 1'b1;
        set_rf(1'b1);
        send_type(0, 0, "R9");
        for (int i = 0; i < 4; i++) send_type(0, 0, "R9");
        send_type(1, 9, "R9");
        send_type(1, 10, "R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule